// File: doc/BRIEF.md
# Probabilistic Neighbor Row Refresher

This block sits beside a DRAM controller and watches its row-close (precharge) events. Each time a row is closed, a 16-bit pseudo-random generator advances one step. When the new value falls below a programmable threshold, the block asks the controller for one extra activation of a row physically adjacent to the one just closed. The extra activation recharges that neighbor, so a row that is opened and closed over and over cannot drain its neighbors for long. On average the neighbors get refreshed before damage builds up, and the block needs no activation counters.

The block keeps nothing per row. Its state is the generator, one pending-request slot and a saturating count of requests it had to drop. The request leaves on a valid/ready handshake carrying a bank and a row, and the controller merges it into its own command stream. The probability is set by `cfg_thresh`: a trigger fires when the new generator value is below it. A value near 328 gives about one trigger in two hundred closes.

Top module: `nbr_refresh_top`

## Requirements
- R1: After reset `req_valid` is 0, `drop_count` is 0 and the generator holds the parameter `SEED`. A zero `SEED` is replaced by 1, so the generator never holds zero.
- R2: The generator advances exactly once in each cycle where `close_valid` is 1, and never in any other cycle. A step shifts the state left by one bit and puts into bit 0 the XOR of old bits 15, 13, 12 and 10.
- R3: A close event triggers exactly when the generator value after its step, read as an unsigned number, is less than `cfg_thresh`. A `cfg_thresh` of 0 never triggers.
- R4: A trigger that finds the slot empty, or finds the slot being accepted in the same cycle, sets `req_valid` on the next clock edge, with `req_bank` equal to the closed bank.
- R5: For a closed row that is neither 0 nor `NUM_ROWS-1`, the requested row is row+1 if bit 15 of the generator before the step was 1. It is row-1 if that bit was 0.
- R6: A closed row 0 always requests row 1. A closed row `NUM_ROWS-1` always requests row `NUM_ROWS-2`.
- R7: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_bank` and `req_row` stay unchanged. A cycle with both at 1 clears the slot unless a new trigger reloads it.
- R8: A trigger that arrives while the slot is full and not being accepted is dropped. The slot keeps its old request, and `drop_count` increases by one, saturating at its maximum.
- R9: A close event that does not trigger changes neither the slot nor `drop_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_thresh | input | 16 | Trigger threshold; probability is about cfg_thresh/65536 |
| close_valid | input | 1 | One-cycle strobe: a row was closed |
| close_bank | input | BANK_W | Bank of the closed row |
| close_row | input | ROW_W | Closed row |
| req_valid | output | 1 | Extra activation request pending |
| req_ready | input | 1 | Controller accepts the request |
| req_bank | output | BANK_W | Bank of the row to activate |
| req_row | output | ROW_W | Neighbor row to activate |
| drop_count | output | CNT_W | Saturating count of dropped triggers |

## Verification
The bench runs a reference generator of its own and predicts every decision cycle by cycle. A threshold of zero shows that no close can ever trigger. A threshold of 0xFFFF makes nearly every close fire. Interior rows then show whether the up/down choice reads the right generator bit. Idle cycles placed between closes show whether the generator moves only on close events. Closes on row 0 and on the last row check the edge handling. Holding ready low while closes keep arriving separates a drop from an overwrite. Raising ready in the same cycle as a new trigger shows that a request is reloaded rather than lost or counted as a drop.

// File: rtl/nbr_refresh_pkg.sv
package nbr_refresh_pkg;

    localparam int LFSR_W = 16;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } nbr_dir_e;

    // x^16 + x^14 + x^13 + x^11 + 1, left-shifting Fibonacci form
    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/nbr_lfsr.sv
module nbr_lfsr
    import nbr_refresh_pkg::*;
#(
    parameter lfsr_t SEED = 16'hACE1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    output lfsr_t cur,
    output lfsr_t nxt
);
    localparam lfsr_t SEED_SAFE = (SEED == '0) ? lfsr_t'(1) : SEED;

    typedef struct packed {
        lfsr_t state;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        nxt  = lfsr_step(st_q.state);
        if (adv) begin
            st_d.state = nxt;
        end
        cur = st_q.state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= SEED_SAFE;
        end else begin
            st_q <= st_d;
        end
    end

    a_r1_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.state != '0);

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.state));

    a_r2_step_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> st_q.state == lfsr_step($past(st_q.state)));

endmodule

// File: rtl/nbr_pick.sv
module nbr_pick
    import nbr_refresh_pkg::*;
#(
    parameter int ROW_W    = 16,
    parameter int NUM_ROWS = 1 << ROW_W
) (
    input  logic [ROW_W-1:0] row_in,
    input  nbr_dir_e         dir,
    output logic [ROW_W-1:0] row_out
);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(NUM_ROWS - 1);
    localparam logic [ROW_W-1:0] ONE  = ROW_W'(1);

    logic at_low, at_high;

    always_comb begin
        at_low  = (row_in == '0);
        at_high = (row_in == LAST);
        if (at_low) begin
            row_out = ONE;
        end else if (at_high) begin
            row_out = LAST - ONE;
        end else if (dir == DIR_UP) begin
            row_out = row_in + ONE;
        end else begin
            row_out = row_in - ONE;
        end
    end

endmodule

// File: rtl/nbr_slot.sv
module nbr_slot #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] load_bank,
    input  logic [ROW_W-1:0]  load_row,
    input  logic              ready,
    output logic              valid,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [CNT_W-1:0]  drops
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [CNT_W-1:0]  drops;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic     leaving;

    always_comb begin
        st_d    = st_q;
        leaving = st_q.vld && ready;
        if (leaving) begin
            st_d.vld = 1'b0;
        end
        if (load) begin
            if (!st_q.vld || leaving) begin
                st_d.vld  = 1'b1;
                st_d.bank = load_bank;
                st_d.row  = load_row;
            end else if (st_q.drops != CNT_MAX) begin
                st_d.drops = st_q.drops + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.vld;
    assign bank  = st_q.bank;
    assign row   = st_q.row;
    assign drops = st_q.drops;

    a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(bank) && $stable(row)));

    a_r8_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (load && valid && !ready && drops != CNT_MAX) |=> drops == $past(drops) + 1'b1);

    a_r9_no_load_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(drops));

    a_r4_load_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (!valid || ready)) |=> valid);

endmodule

// File: rtl/nbr_refresh_top.sv
module nbr_refresh_top
    import nbr_refresh_pkg::*;
#(
    parameter int    BANK_W   = 3,
    parameter int    ROW_W    = 16,
    parameter int    NUM_ROWS = 1 << ROW_W,
    parameter int    CNT_W    = 16,
    parameter lfsr_t SEED     = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cfg_thresh,
    input  logic              close_valid,
    input  logic [BANK_W-1:0] close_bank,
    input  logic [ROW_W-1:0]  close_row,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [BANK_W-1:0] req_bank,
    output logic [ROW_W-1:0]  req_row,
    output logic [CNT_W-1:0]  drop_count
);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(NUM_ROWS - 1);

    lfsr_t            rnd_cur, rnd_nxt;
    logic             hit;
    nbr_dir_e         dir;
    logic [ROW_W-1:0] target;

    nbr_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (close_valid),
        .cur   (rnd_cur),
        .nxt   (rnd_nxt)
    );

    always_comb begin
        hit = close_valid && (rnd_nxt < cfg_thresh);
        dir = rnd_cur[LFSR_W-1] ? DIR_UP : DIR_DOWN;
    end

    nbr_pick #(.ROW_W(ROW_W), .NUM_ROWS(NUM_ROWS)) u_pick (
        .row_in  (close_row),
        .dir     (dir),
        .row_out (target)
    );

    nbr_slot #(.BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hit),
        .load_bank (close_bank),
        .load_row  (target),
        .ready     (req_ready),
        .valid     (req_valid),
        .bank      (req_bank),
        .row       (req_row),
        .drops     (drop_count)
    );

    a_r3_zero_threshold_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_thresh == '0 && (!req_valid || req_ready)) |=> !req_valid);

    a_r6_low_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && close_row == '0 && (!req_valid || req_ready)) |=> req_row == ROW_W'(1));

    a_r6_high_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && close_row == LAST && (!req_valid || req_ready)) |=> req_row == LAST - 1'b1);

    a_r4_bank_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (!req_valid || req_ready)) |=> req_bank == $past(close_bank));

endmodule

// File: tb/sim_nbr_refresh_top.sv
`timescale 1ns/1ps
module sim_nbr_refresh_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_thresh = '0;
    logic        close_valid = 1'b0;
    logic [2:0]  close_bank = '0;
    logic [15:0] close_row = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [2:0]  req_bank;
    logic [15:0] req_row;
    logic [15:0] drop_count;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    nbr_refresh_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh),
        .close_valid(close_valid), .close_bank(close_bank), .close_row(close_row),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .drop_count(drop_count)
    );

    // independent reference state
    logic [15:0] m_lfsr;
    logic        m_vld;
    logic [2:0]  m_bank;
    logic [15:0] m_row;
    logic [15:0] m_drop;
    int          m_ups, m_downs;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        close_valid = 1'b0;
        req_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_lfsr = 16'hACE1; m_vld = 1'b0; m_bank = '0; m_row = '0; m_drop = '0;
    endtask

    // one cycle: drive at negedge, model the edge, check at the next negedge
    task automatic step(input string req, input logic cv, input logic [2:0] b,
                        input logic [15:0] r, input logic rdy);
        logic [15:0] old, nxt, tgt;
        logic        trig, leave;
        close_valid = cv; close_bank = b; close_row = r; req_ready = rdy;
        trig = 1'b0; tgt = '0;
        if (cv) begin
            old = m_lfsr;
            nxt = {old[14:0], old[15] ^ old[13] ^ old[12] ^ old[10]};
            m_lfsr = nxt;
            trig = (nxt < cfg_thresh);
            if (r == 16'h0)         tgt = 16'h1;
            else if (r == 16'hFFFF) tgt = 16'hFFFE;
            else if (old[15])  begin tgt = r + 16'h1; m_ups++;   end
            else               begin tgt = r - 16'h1; m_downs++; end
        end
        leave = m_vld && rdy;
        if (leave) m_vld = 1'b0;
        if (trig) begin
            if (!m_vld) begin
                m_vld = 1'b1; m_bank = b; m_row = tgt;
            end else if (m_drop != 16'hFFFF) begin
                m_drop = m_drop + 16'h1;
            end
        end
        @(negedge clk);
        close_valid = 1'b0;
        chk({req, " valid"}, {31'd0, req_valid}, {31'd0, m_vld});
        chk({req, " drops"}, {16'd0, drop_count}, {16'd0, m_drop});
        if (m_vld) begin
            chk({req, " bank"}, {29'd0, req_bank}, {29'd0, m_bank});
            chk({req, " row"}, {16'd0, req_row}, {16'd0, m_row});
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset valid", {31'd0, req_valid}, 32'd0);
        chk("R1 reset drops", {16'd0, drop_count}, 32'd0);
    endtask

    task automatic t_zero_thresh();
        do_reset();
        cfg_thresh = 16'h0;
        for (int i = 0; i < 60; i++) step("R3 zero threshold", 1'b1, 3'(i), 16'(100 + i), 1'b0);
    endtask

    task automatic t_interior();
        do_reset();
        cfg_thresh = 16'hFFFF;
        m_ups = 0; m_downs = 0;
        for (int i = 0; i < 40; i++) begin
            step("R5 R4 interior", 1'b1, 3'(i), 16'(1000 + 7 * i), 1'b1);
            if (i % 3 == 0) step("R2 idle gap", 1'b0, '0, '0, 1'b1);
        end
        n_tests++;
        if (m_ups == 0 || m_downs == 0) begin
            n_fail++;
            $display("FAIL R5: actual ups %0d downs %0d, expected both nonzero", m_ups, m_downs);
        end
    endtask

    task automatic t_edges();
        do_reset();
        cfg_thresh = 16'hFFFF;
        for (int i = 0; i < 8; i++) begin
            step("R6 row zero", 1'b1, 3'd2, 16'h0000, 1'b1);
            step("R6 last row", 1'b1, 3'd5, 16'hFFFF, 1'b1);
        end
    endtask

    task automatic t_backpressure();
        do_reset();
        cfg_thresh = 16'hFFFF;
        step("R4 first load", 1'b1, 3'd1, 16'd500, 1'b0);
        for (int i = 0; i < 3; i++) step("R7 hold", 1'b0, '0, '0, 1'b0);
        for (int i = 0; i < 5; i++) step("R8 drop", 1'b1, 3'd6, 16'(900 + i), 1'b0);
        step("R9 reload on accept", 1'b1, 3'd3, 16'd2000, 1'b1);
        step("R7 drain", 1'b0, '0, '0, 1'b1);
        cfg_thresh = 16'h0;
        step("R9 no trigger", 1'b1, 3'd4, 16'd77, 1'b0);
    endtask

    task automatic t_nominal();
        do_reset();
        cfg_thresh = 16'd328;
        for (int i = 0; i < 3000; i++) step("R3 nominal rate", 1'b1, 3'(i), 16'(i * 13 + 5), i[2]);
    endtask

    initial begin
        t_reset();
        t_zero_thresh();
        t_interior();
        t_edges();
        t_backpressure();
        t_nominal();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule